// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address used for each beat of a four-beat memory burst. When a burst begins, it captures the whole external address. The upper bits are then held unchanged for the rest of the burst. The two low bits become the first beat's address. Each later advance request moves a two-bit beat counter forward, and the low address bits are formed from the captured start value and that counter.

A static mode input selects one of two orderings:
- **Interleaved:** each beat address is the start value XOR the beat count.
- **Linear:** the start value plus the beat count, wrapping modulo four.

The sequencer holds its address whenever neither a start nor an advance is requested. A memory controller can therefore insert wait cycles in the middle of a burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high at a rising clock edge, the beat index becomes 0 and the whole output address becomes 0.
- R2: A start request (`start_i` = 1) at an edge captures `ext_addr_i`. After that edge the output address equals the captured address and the beat index is 0.
- R3: With `mode_i` = 1 (interleaved), the low two output bits equal the captured start bits XOR the beat index. For example, start 01 gives 01, 00, 11, 10.
- R4: With `mode_i` = 0 (linear), the low two output bits equal the captured start bits plus the beat index, modulo 4. For example, start 11 gives 11, 00, 01, 10.
- R5: An advance request (`adv_i` = 1) at an edge with no start request increments the beat index by one.
- R6: With neither start nor advance requested at an edge, the beat index and the output address are unchanged.
- R7: When start and advance are both requested at the same edge, the start wins. The new start value is loaded and the beat index is 0.
- R8: An advance from beat index 3 returns the index to 0. The same four-address pattern then repeats.
- R9: The output bits above bit 1 change only at a start edge or at reset. Changes on the upper bits of `ext_addr_i` between starts have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst from `ext_addr_i` |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | 2 | Current beat index |

## Verification
Start and advance can both be requested at the same edge, and this case is the main conflict the block resolves. The bench provokes it with directed cycles in which both requests are high during a burst, using a start value different from the one in use. It also provokes it through random stimulus in which both requests fire independently. After each such edge the bench expects the new start value at beat 0 and never an incremented index. A reference model built from the ordering rules judges every cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned LOW_W = 2;
  typedef logic [LOW_W-1:0] beat_t;

  function automatic beat_t ilv_addr(input beat_t base, input beat_t beat);
    return base ^ beat;
  endfunction

  function automatic beat_t lin_addr(input beat_t base, input beat_t beat);
    return beat_t'(base + beat);
  endfunction

  function automatic beat_t next_beat(input beat_t beat);
    return beat_t'(beat + 1'b1);
  endfunction
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  start_i,
  input  logic  adv_i,
  input  beat_t ext_low_i,
  output beat_t base_o,
  output beat_t beat_o,
  output logic  load_ev_o,
  output logic  step_ev_o
);
  beat_t base_q, beat_q;

  assign load_ev_o = start_i;
  assign step_ev_o = adv_i & ~start_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_ev_o) begin
      base_q <= ext_low_i;
      beat_q <= '0;
    end else if (step_ev_o) begin
      beat_q <= next_beat(beat_q);
    end
  end

  assign base_o = base_q;
  assign beat_o = beat_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(start_i) && !$past(rst_i)) |-> (beat_q == '0 && base_q == $past(ext_low_i)));
  assert_prio_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(start_i) && $past(adv_i) && !$past(rst_i)) |-> (beat_q == '0));
  assert_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(adv_i) && !$past(start_i) && !$past(rst_i)) |-> (beat_q == beat_t'($past(beat_q) + 1'b1)));
  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(adv_i) && !$past(start_i) && !$past(rst_i) && $past(beat_q) == 2'd3) |-> (beat_q == 2'd0));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(adv_i) && !$past(start_i) && !$past(rst_i)) |-> ($stable(beat_q) && $stable(base_q)));
endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg #(
  parameter int unsigned UPPER_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               load_i,
  input  logic [UPPER_W-1:0] ext_upper_i,
  output logic [UPPER_W-1:0] upper_o
);
  logic [UPPER_W-1:0] upper_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       upper_q <= '0;
    else if (load_i) upper_q <= ext_upper_i;
  end

  assign upper_o = upper_q;

  assert_upper_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(load_i) && !$past(rst_i)) |-> $stable(upper_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  logic  mode_i,
  input  beat_t base_i,
  input  beat_t beat_i,
  output beat_t low_o
);
  beat_t ilv, lin;

  assign ilv   = ilv_addr(base_i, beat_i);
  assign lin   = lin_addr(base_i, beat_i);
  assign low_o = mode_i ? ilv : lin;

  always_comb begin
    if (beat_i == '0) begin
      assert_first_R2: assert (low_o == base_i);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LOW_W-1:0]  beat_o
);
  localparam int unsigned UPPER_W = ADDR_W - LOW_W;

  beat_t base_w, beat_w, low_w;
  logic  load_ev, step_ev;
  logic [UPPER_W-1:0] upper_w;

  burst_seq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start_i),
    .adv_i     (adv_i),
    .ext_low_i (ext_addr_i[LOW_W-1:0]),
    .base_o    (base_w),
    .beat_o    (beat_w),
    .load_ev_o (load_ev),
    .step_ev_o (step_ev)
  );

  burst_upper_reg #(.UPPER_W(UPPER_W)) u_upper (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .load_i      (load_ev),
    .ext_upper_i (ext_addr_i[ADDR_W-1:LOW_W]),
    .upper_o     (upper_w)
  );

  burst_order_map u_map (
    .mode_i (mode_i),
    .base_i (base_w),
    .beat_i (beat_w),
    .low_o  (low_w)
  );

  assign addr_o = {upper_w, low_w};
  assign beat_o = beat_w;

  assert_events_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !(load_ev && step_ev));
  assert_reset_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (addr_o == '0 && beat_o == '0));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, adv = 1'b0, mode = 1'b1;
  logic [AW-1:0] ext = '0;
  logic [AW-1:0] addr;
  logic [1:0] beat;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] m_base = 0, m_beat = 0;
  logic [AW-3:0] m_up = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_i(rst), .start_i(start), .adv_i(adv), .mode_i(mode),
    .ext_addr_i(ext), .addr_o(addr), .beat_o(beat)
  );

  // interleaved: flip the start bits wherever the beat has a one
  function automatic logic [1:0] exp_ilv(input logic [1:0] s, input logic [1:0] b);
    return {b[1] ? ~s[1] : s[1], b[0] ? ~s[0] : s[0]};
  endfunction

  // linear: walk forward b times, wrapping 3 -> 0
  function automatic logic [1:0] exp_lin(input logic [1:0] s, input logic [1:0] b);
    logic [1:0] a = s;
    for (int i = 0; i < int'(b); i++) a = (a == 2'd3) ? 2'd0 : a + 2'd1;
    return a;
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_up, mode ? exp_ilv(m_base, m_beat) : exp_lin(m_base, m_beat)};
  endfunction

  task automatic check(input string req);
    checks++;
    if (addr !== exp_addr() || beat !== m_beat) begin
      errors++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr, beat, exp_addr(), m_beat);
    end
  endtask

  // called at a negedge: drive, take one edge, update model, check at next negedge
  task automatic cyc(input logic s, input logic a, input logic [AW-1:0] e, input string req);
    start = s; adv = a; ext = e;
    @(posedge clk);
    if (rst) begin m_base = 0; m_beat = 0; m_up = 0; end
    else if (s) begin m_base = e[1:0]; m_beat = 0; m_up = e[AW-1:2]; end
    else if (a) m_beat = m_beat + 2'd1;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    cyc(1'b1, 1'b1, 17'h1ABCD, "R1");
    rst = 1'b0;
    // R2 / R3: interleaved from 01
    mode = 1'b1;
    cyc(1'b1, 1'b0, 17'h12345, "R2");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 17'h00000, "R3");
    cyc(1'b0, 1'b1, 17'h00000, "R8");
    cyc(1'b0, 1'b1, 17'h00000, "R8");
    // R4: linear from 11 with a wait cycle
    mode = 1'b0;
    cyc(1'b1, 1'b0, 17'h0F0F3, "R2");
    cyc(1'b0, 1'b1, 17'h0F0F3, "R4");
    cyc(1'b0, 1'b0, 17'h1FFFF, "R6");
    cyc(1'b0, 1'b0, 17'h00000, "R6");
    cyc(1'b0, 1'b1, 17'h1FFFF, "R9");
    cyc(1'b0, 1'b1, 17'h00000, "R4");
    cyc(1'b0, 1'b1, 17'h00000, "R8");
    // R7: start and advance together mid-burst
    cyc(1'b0, 1'b1, 17'h00000, "R5");
    cyc(1'b1, 1'b1, 17'h15556, "R7");
    cyc(1'b0, 1'b1, 17'h00000, "R4");
    mode = 1'b1;
    cyc(1'b1, 1'b1, 17'h0AAA8, "R7");
    cyc(1'b0, 1'b1, 17'h00000, "R3");
    // random phase
    for (int n = 0; n < 2000; n++) begin
      logic s, a;
      logic [AW-1:0] e;
      if (n % 97 == 0) mode = $urandom_range(0, 1);
      s = ($urandom_range(0, 5) == 0);
      a = ($urandom_range(0, 2) != 0);
      e = AW'($urandom);
      cyc(s, a, e, s ? (a ? "R7" : "R2") : (a ? (mode ? "R3" : "R4") : "R6"));
    end
    rst = 1'b1;
    cyc(1'b0, 1'b1, 17'h00000, "R1");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule